// File: doc/BRIEF.md
# Multiply-High-Word Execution Unit

This execution unit returns the upper 32 bits of a 32 by 32 multiply for a 64-bit datapath. Each operand arrives as a full 64-bit register value, but only its low word enters the multiply. A signed flag picks two's-complement or unsigned treatment of those low words. In signed mode each word is reduced to a magnitude with bit 31 as the sign. The unsigned magnitudes are multiplied, and the 64-bit product is negated when the two signs differ.

The high word of the product is written twice, once into each half of the 64-bit result. The unit takes one operation per clock and presents its result a fixed two cycles later. Operations with the wrong operation code, or issued without the 32-bit-mode flag, are refused. The summary-overflow bit is not computed here. It rides the pipeline untouched, so it stays aligned with the result it accompanies.

Top module: `mulhw_unit`

## Requirements
- R1: An accepted operation (in_valid=1, op_code equal to OPC_HI_WORD, default 7'h2B, and word_mode=1) raises out_valid exactly two clock edges later; back-to-back operations are accepted on every cycle and emerge in order.
- R2: An operation offered with word_mode=0, or with any other op_code, is refused: out_valid stays 0 two edges later.
- R3: Bits 63..32 of ra and rb have no effect on the result.
- R4: With signed_mode=0 the product is the unsigned product of ra[31:0] and rb[31:0].
- R5: With signed_mode=1 each low word is replaced by its magnitude (bit 31 is the sign), the magnitudes are multiplied, and the product is negated when exactly one sign bit is set.
- R6: In signed mode, 32'h8000_0000 has magnitude 2^31, so it squared gives 2^62 and a high word of 32'h4000_0000.
- R7: When out_valid is 1, result[63:32] and result[31:0] both equal bits 63..32 of the product.
- R8: ov_sum_out equals the ov_sum_in presented two edges earlier, whatever the operation and whether or not it was accepted.
- R9: While reset is active, out_valid, result and ov_sum_out are all 0.
- R10: Whenever out_valid is 0, result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered this cycle |
| op_code | input | 7 | Operation-type code; only OPC_HI_WORD is executed |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| word_mode | input | 1 | 32-bit-mode flag; must be 1 for the operation to be legal |
| ra | input | 64 | First register operand |
| rb | input | 64 | Second register operand |
| ov_sum_in | input | 1 | Summary-overflow bit entering the unit |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Product high word, repeated in both halves |
| ov_sum_out | output | 1 | Summary-overflow bit, passed through with the result's latency |

## Verification
Every internal fault reaches the ports exactly two edges after the operation that exposes it. A wrong magnitude or a misapplied sign flip corrupts the result's high word on the output cycle of that same operation. Stimulus that puts 32'h8000_0000 or mixed signs on the inputs brings such faults out at once. A valid bit that is dropped or gated wrongly shows as a missing or spurious out_valid. A fault in the replication step shows as halves that disagree. A summary-overflow stage that is skipped or doubled shows as a one-cycle shift against a toggling ov_sum_in.

// File: rtl/mulhw_pkg.sv
package mulhw_pkg;
  localparam int unsigned MULHW_OPC_W = 7;
  localparam logic [MULHW_OPC_W-1:0] MULHW_OPC_HI_WORD = 7'h2B;

  typedef struct packed {
    logic valid;
    logic neg;
    logic ovs;
  } mulhw_ctl_t;
endpackage

// File: rtl/mulhw_operand_prep.sv
module mulhw_operand_prep #(
  parameter int unsigned HALF_W = 32
) (
  input  logic [HALF_W-1:0] low_word,
  input  logic              signed_mode,
  output logic [HALF_W-1:0] magnitude,
  output logic              is_negative
);
  function automatic logic [HALF_W-1:0] abs_field(input logic [HALF_W-1:0] v,
                                                  input logic sgn);
    return sgn ? (~v + 1'b1) : v;
  endfunction

  always_comb begin
    is_negative = signed_mode & low_word[HALF_W-1];
    magnitude   = abs_field(low_word, is_negative);
  end

  // R5: a magnitude never exceeds 2^(HALF_W-1) in signed mode
  always_comb begin
    if (signed_mode)
      a_r5_mag_range: assert (magnitude <= {1'b1, {(HALF_W-1){1'b0}}});
  end
endmodule

// File: rtl/mulhw_core.sv
module mulhw_core #(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              neg,
  input  logic [HALF_W-1:0] mag_a,
  input  logic [HALF_W-1:0] mag_b,
  output logic              out_valid,
  output logic [PROD_W-1:0] prod
);
  function automatic logic [PROD_W-1:0] cond_negate(input logic [PROD_W-1:0] v,
                                                    input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  logic [PROD_W-1:0] mag_prod;
  logic [PROD_W-1:0] fixed_prod;

  assign mag_prod   = {{HALF_W{1'b0}}, mag_a} * {{HALF_W{1'b0}}, mag_b};
  assign fixed_prod = cond_negate(mag_prod, neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      prod      <= '0;
    end else begin
      out_valid <= in_valid;
      prod      <= in_valid ? fixed_prod : '0;
    end
  end

  // R5: a nonzero magnitude product with differing signs comes out negative
  a_r5_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && neg && mag_a != '0 && mag_b != '0) |=> prod[PROD_W-1]);

  // R5: equal signs never yield a negative product
  a_r5_pos_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !neg) |=> !prod[PROD_W-1] || $past(mag_a[HALF_W-1] && mag_b[HALF_W-1]));
endmodule

// File: rtl/mulhw_pack.sv
module mulhw_pack #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned XLEN   = 64,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned COPIES = XLEN / HALF_W
) (
  input  logic [PROD_W-1:0] prod,
  output logic [XLEN-1:0]   packed_out
);
  logic [HALF_W-1:0] hi_word;
  logic [HALF_W-1:0] unused_lo;

  assign hi_word   = prod[PROD_W-1:HALF_W];
  assign unused_lo = prod[HALF_W-1:0];

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    assign packed_out[g*HALF_W +: HALF_W] = hi_word;
  end
endmodule

// File: rtl/mulhw_unit.sv
module mulhw_unit
  import mulhw_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned OPC_W  = MULHW_OPC_W,
  parameter logic [OPC_W-1:0] OPC_HI_WORD = MULHW_OPC_HI_WORD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic             signed_mode,
  input  logic             word_mode,
  input  logic [XLEN-1:0]  ra,
  input  logic [XLEN-1:0]  rb,
  input  logic             ov_sum_in,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             ov_sum_out
);
  localparam int unsigned PROD_W = 2 * HALF_W;

  logic accept;
  assign accept = in_valid & word_mode & (op_code == OPC_HI_WORD);

  // upper operand halves are deliberately dropped
  logic [XLEN-HALF_W-1:0] unused_hi_a, unused_hi_b;
  assign unused_hi_a = ra[XLEN-1:HALF_W];
  assign unused_hi_b = rb[XLEN-1:HALF_W];

  logic [HALF_W-1:0] low_w    [2];
  logic [HALF_W-1:0] mag_w    [2];
  logic              sign_w   [2];
  assign low_w[0] = ra[HALF_W-1:0];
  assign low_w[1] = rb[HALF_W-1:0];

  for (genvar k = 0; k < 2; k++) begin : g_prep
    mulhw_operand_prep #(.HALF_W(HALF_W)) u_prep (
      .low_word    (low_w[k]),
      .signed_mode (signed_mode),
      .magnitude   (mag_w[k]),
      .is_negative (sign_w[k])
    );
  end

  // stage 1
  mulhw_ctl_t        s1_ctl;
  logic [HALF_W-1:0] s1_mag_a, s1_mag_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ctl   <= '0;
      s1_mag_a <= '0;
      s1_mag_b <= '0;
    end else begin
      s1_ctl.valid <= accept;
      s1_ctl.neg   <= sign_w[0] ^ sign_w[1];
      s1_ctl.ovs   <= ov_sum_in;
      s1_mag_a     <= mag_w[0];
      s1_mag_b     <= mag_w[1];
    end
  end

  // stage 2
  logic [PROD_W-1:0] prod_q;

  mulhw_core #(.HALF_W(HALF_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s1_ctl.valid),
    .neg       (s1_ctl.neg),
    .mag_a     (s1_mag_a),
    .mag_b     (s1_mag_b),
    .out_valid (out_valid),
    .prod      (prod_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_sum_out <= 1'b0;
    else        ov_sum_out <= s1_ctl.ovs;
  end

  mulhw_pack #(.HALF_W(HALF_W), .XLEN(XLEN)) u_pack (
    .prod       (prod_q),
    .packed_out (result)
  );

  // edges since reset, for assertions that look two cycles back
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R1 / R2: validity appears exactly two edges after acceptance
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (out_valid == $past(accept, 2)));

  // R8: summary overflow rides along unchanged
  a_r8_ov_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (ov_sum_out == $past(ov_sum_in, 2)));

  // R7: both halves carry the same word
  a_r7_halves_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result[XLEN-1:HALF_W] == result[HALF_W-1:0]));

  // R10: no stale data while idle
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (result == '0));
endmodule

// File: tb/mulhw_unit_test.sv
module mulhw_unit_test;
  localparam logic [6:0] OPC = 7'h2B;
  localparam int NV = 13;
  // {ra, rb, signed, expected high word}
  localparam logic [160:0] VEC [NV] = '{
    {64'h0, 64'h0, 1'b0, 32'h0000_0000},                                   // R4 zero
    {64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0, 32'hFFFF_FFFE}, // R4 all ones
    {64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b1, 32'h0000_0000}, // R5 -1*-1
    {64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b1, 32'hFFFF_FFFF}, // R5 -1*1
    {64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b1, 32'h4000_0000}, // R6
    {64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b0, 32'h4000_0000}, // R4
    {64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 1'b1, 32'hFFFF_FFFF}, // R6 min*1
    {64'h0000_0000_0001_0000, 64'h0000_0000_0001_0000, 1'b0, 32'h0000_0001}, // R4 2^32
    {64'hDEAD_BEEF_0000_0003, 64'h1234_5678_0000_0005, 1'b0, 32'h0000_0000}, // R3
    {64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 1'b1, 32'h3FFF_FFFF}, // R5 max^2
    {64'h0000_0000_FFFF_FFFE, 64'h0000_0000_7FFF_FFFF, 1'b1, 32'hFFFF_FFFF}, // R5 -2*max
    {64'h0000_0000_0000_0003, 64'h0000_0000_FFFF_FFFD, 1'b1, 32'hFFFF_FFFF}, // R5 3*-3
    {64'hFFFF_FFFF_0000_0003, 64'h0000_0000_FFFF_FFFD, 1'b0, 32'h0000_0002}  // R3 R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [6:0]  op_code = '0;
  logic        signed_mode = 1'b0;
  logic        word_mode = 1'b0;
  logic [63:0] ra = '0, rb = '0;
  logic        ov_sum_in = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        ov_sum_out;
  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mulhw_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .signed_mode(signed_mode), .word_mode(word_mode), .ra(ra), .rb(rb),
    .ov_sum_in(ov_sum_in), .out_valid(out_valid), .result(result),
    .ov_sum_out(ov_sum_out)
  );

  function automatic logic [31:0] ref_hi(input logic [63:0] a, input logic [63:0] b,
                                         input logic sgn);
    longint p;
    if (sgn) p = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
    else     p = longint'({32'h0, a[31:0]}) * longint'({32'h0, b[31:0]});
    return p[63:32];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one op at a negedge, idle after one edge, return at the negedge after the output edge
  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic sgn,
                        input logic [6:0] opc, input logic wm, input logic ov);
    @(negedge clk);
    in_valid = 1'b1; op_code = opc; word_mode = wm; signed_mode = sgn;
    ra = a; rb = b; ov_sum_in = ov;
    @(negedge clk);
    in_valid = 1'b0; ov_sum_in = ~ov;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R9 reset state
    ov_sum_in = 1'b1; in_valid = 1'b1; word_mode = 1'b1; op_code = OPC;
    repeat (3) @(negedge clk);
    check("R9 out_valid", {63'h0, out_valid}, 64'h0);
    check("R9 result", result, 64'h0);
    check("R9 ov_sum_out", {63'h0, ov_sum_out}, 64'h0);
    in_valid = 1'b0; ov_sum_in = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [31:0] e;
      e = VEC[i][31:0];
      run_op(VEC[i][160:97], VEC[i][96:33], VEC[i][32], OPC, 1'b1, i[0]);
      check("R1 valid", {63'h0, out_valid}, 64'h1);
      check("R4 R5 R7 table result", result, {e, e});
      check("R5 reference", {32'h0, result[31:0]}, {32'h0, ref_hi(VEC[i][160:97], VEC[i][96:33], VEC[i][32])});
      check("R8 ov", {63'h0, ov_sum_out}, {63'h0, i[0]});
    end

    // random vectors against reference, both modes
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a, b;
      logic [31:0] e;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      e = ref_hi(a, b, i[0]);
      run_op(a, b, i[0], OPC, 1'b1, 1'b0);
      check("R4 R5 random", result, {e, e});
    end

    // R2 refusals, R10 zero while idle, R8 ov on refused ops
    run_op(64'h5, 64'h7, 1'b0, OPC, 1'b0, 1'b1);
    check("R2 word_mode=0 valid", {63'h0, out_valid}, 64'h0);
    check("R10 idle result", result, 64'h0);
    check("R8 ov on refused op", {63'h0, ov_sum_out}, 64'h1);
    run_op(64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b0, 7'h2A, 1'b1, 1'b0);
    check("R2 wrong opcode valid", {63'h0, out_valid}, 64'h0);
    check("R10 idle result", result, 64'h0);
    check("R8 ov low", {63'h0, ov_sum_out}, 64'h0);

    // R1 back-to-back stream, one per cycle
    begin
      logic [31:0] exp_q [6];
      logic        ov_q  [6];
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        if (j >= 2) begin
          check("R1 stream valid", {63'h0, out_valid}, 64'h1);
          check("R1 stream result", result, {exp_q[j-2], exp_q[j-2]});
          check("R8 stream ov", {63'h0, ov_sum_out}, {63'h0, ov_q[j-2]});
        end
        if (j < 6) begin
          in_valid = 1'b1; op_code = OPC; word_mode = 1'b1; signed_mode = j[0];
          ra = {32'hA5A5_A5A5, 32'h8000_0000 - j}; rb = {32'h0, 32'h1000 * (j + 1)};
          ov_sum_in = j[1];
          exp_q[j] = ref_hi(ra, rb, j[0]);
          ov_q[j] = j[1];
        end else begin
          in_valid = 1'b0;
        end
      end
      @(negedge clk);
      check("R10 after stream", {63'h0, out_valid}, 64'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule